// File: doc/BRIEF.md
# Longest-Prefix Lookup Walker with Direct Array and Six-Way Nodes

The block resolves a destination address to a forwarding result in two stages. The upper 16 bits of the address index a directly addressed array. An array entry either carries the final result or names the root node of a small search tree. Each tree node is one 256-bit memory line with five sorted 16-bit keys and eleven 16-bit pointers. The walker compares a 16-bit slice of the address against all five keys in one cycle. It then follows the selected pointer until that pointer carries a result.

Lookups enter through a valid/ready request. The answer leaves as a one-cycle response pulse that carries a 15-bit result and an error flag. Both the array and the nodes are read through one line-wide read port: a select bit picks the store, and a valid strobe returns the data after whatever latency the memory has. A multicolumn mode is available for addresses longer than 32 bits. In that mode an equal match moves the search key on to the next 16-bit slice of the address. A depth limit ends a walk that reads too many nodes.

Top module: `lpm_walker`

## Requirements
- R1: The first read after a request is an array read (mem_rd_node=0) at address bits [ADDR_W-1:ADDR_W-16]. When that entry is a result, the response follows with no node read.
- R2: A pointer is 16 bits. Bit 15 set marks a result, and bits [14:0] are then the response value. Bit 15 clear marks a next node, and bits [14:0] are then its node address, read with mem_rd_node=1 and mem_rd_addr={1'b0,bits[14:0]}. An array entry sits in bits [15:0] of the returned line.
- R3: Node slot s occupies line bits [16s+15:16s]. Slots 0..4 hold the keys in non-decreasing order. Slots 5..9 hold the equal pointers for keys 0..4. Slots 10..15 hold range pointers 0..5, where range pointer j covers keys with exactly j node keys below them.
- R4: When the search key equals one or more node keys, the equal pointer of the lowest-numbered equal key is followed.
- R5: When no node key equals the search key, range pointer j is followed, where j is the number of node keys strictly less than the search key. Unused key slots are padded with 0xFFFF.
- R6: The first node uses column 0, which is address bits [ADDR_W-17:ADDR_W-32]. With mcol_en low, every node of the walk uses column 0.
- R7: With mcol_en high, following an equal pointer to another node moves the search key to the next lower 16-bit column, and it stays on the last column once there. The column never moves back during a walk.
- R8: A walk reads at most MAX_DEPTH nodes. If the node read in position MAX_DEPTH selects a next-node pointer, the response has rsp_err=1 and rsp_info=0.
- R9: req_ready is high only when idle, and no read is issued while idle. Every accepted request produces exactly one single-cycle rsp_valid pulse.
- R10: After reset, req_ready=1, rsp_valid=0 and mem_rd_en=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_addr | input | ADDR_W | Address to resolve |
| mcol_en | input | 1 | Multicolumn mode, held stable during a lookup |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_info | output | 15 | Result payload |
| rsp_err | output | 1 | Depth limit exceeded |
| mem_rd_en | output | 1 | Read request strobe |
| mem_rd_node | output | 1 | 1 = node store, 0 = array store |
| mem_rd_addr | output | 16 | Read address |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 256 | Returned line |

## Verification
The assertions check on every cycle that the handshake holds: no read while idle, and a response that lasts exactly one cycle. They also check that the array read comes before any node read, that the node-read count never passes the limit, that an error response carries a zero payload, and that the search column only moves forward. Pointer selection inside a node can only be shown by the bench's scenarios. These cover lowest-index choice among duplicate keys, range choice at and around every key boundary, and the column shift on equal hits. The bench also counts node reads for direct array results, for a chain of exactly the maximum depth, and for a self-looping node that must end in an error.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    localparam int KEY_W   = 16;
    localparam int NKEYS   = 5;
    localparam int NSLOTS  = 3 * NKEYS + 1;
    localparam int LINE_W  = KEY_W * NSLOTS;
    localparam int PAY_W   = KEY_W - 1;

    typedef logic [KEY_W-1:0] key_t;

    typedef struct packed {
        logic             is_info;
        logic [PAY_W-1:0] pay;
    } ptr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARR_RD,
        ST_ARR_WAIT,
        ST_NODE_RD,
        ST_NODE_WAIT,
        ST_EVAL,
        ST_RESP
    } walk_st_t;
endpackage

// File: rtl/lpm_col_mux.sv
module lpm_col_mux
    import lpm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NCOL   = (ADDR_W - KEY_W) / KEY_W,
    parameter int COL_W  = (NCOL > 1) ? $clog2(NCOL) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [COL_W-1:0]  col,
    output key_t              key
);
    key_t cols [NCOL];

    generate
        for (genvar c = 0; c < NCOL; c++) begin : g_col
            assign cols[c] = addr[ADDR_W-KEY_W-1-KEY_W*c -: KEY_W];
        end
    endgenerate

    assign key = cols[col];
endmodule

// File: rtl/lpm_node_cmp.sv
module lpm_node_cmp
    import lpm_pkg::*;
#(
    parameter int NK    = NKEYS,
    parameter int CNT_W = $clog2(NK + 1),
    parameter int IDX_W = (NK > 1) ? $clog2(NK) : 1
) (
    input  logic [KEY_W*(3*NK+1)-1:0] line,
    input  key_t                      key,
    output ptr_t                      pick,
    output logic                      eq_hit
);
    logic [NK-1:0]    eq_vec;
    logic [NK-1:0]    lt_vec;
    logic [CNT_W-1:0] lt_cnt;
    logic [IDX_W-1:0] eq_idx;

    generate
        for (genvar i = 0; i < NK; i++) begin : g_key
            assign eq_vec[i] = (line[KEY_W*i +: KEY_W] == key);
            assign lt_vec[i] = (line[KEY_W*i +: KEY_W] <  key);
        end
    endgenerate

    always_comb begin
        lt_cnt = '0;
        eq_idx = '0;
        for (int i = 0; i < NK; i++) begin
            lt_cnt = lt_cnt + CNT_W'(lt_vec[i]);
        end
        for (int i = NK - 1; i >= 0; i--) begin
            if (eq_vec[i]) eq_idx = IDX_W'(i);
        end
        eq_hit = |eq_vec;
        if (eq_hit)
            pick = ptr_t'(line[KEY_W*(NK + int'(eq_idx)) +: KEY_W]);
        else
            pick = ptr_t'(line[KEY_W*(2*NK + int'(lt_cnt)) +: KEY_W]);
    end
endmodule

// File: rtl/lpm_walker.sv
module lpm_walker
    import lpm_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MAX_DEPTH = 4,
    parameter int NCOL      = (ADDR_W - KEY_W) / KEY_W,
    parameter int COL_W     = (NCOL > 1) ? $clog2(NCOL) : 1,
    parameter int DEP_W     = $clog2(MAX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              mcol_en,
    output logic              rsp_valid,
    output logic [PAY_W-1:0]  rsp_info,
    output logic              rsp_err,
    output logic              mem_rd_en,
    output logic              mem_rd_node,
    output logic [KEY_W-1:0]  mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [LINE_W-1:0] mem_rd_data
);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(NCOL - 1);

    walk_st_t          st_q;
    logic [ADDR_W-1:0] addr_q;
    logic [PAY_W-1:0]  node_q;
    logic [COL_W-1:0]  col_q;
    logic [DEP_W-1:0]  depth_q;
    logic [LINE_W-1:0] line_q;
    logic [PAY_W-1:0]  info_q;
    logic              err_q;

    key_t cur_key;
    ptr_t pick;
    logic eq_hit;
    ptr_t arr_ptr;

    lpm_col_mux #(.ADDR_W(ADDR_W), .NCOL(NCOL), .COL_W(COL_W)) u_col (
        .addr (addr_q),
        .col  (col_q),
        .key  (cur_key)
    );

    lpm_node_cmp #(.NK(NKEYS)) u_cmp (
        .line   (line_q),
        .key    (cur_key),
        .pick   (pick),
        .eq_hit (eq_hit)
    );

    assign arr_ptr     = ptr_t'(mem_rd_data[KEY_W-1:0]);
    assign req_ready   = (st_q == ST_IDLE);
    assign rsp_valid   = (st_q == ST_RESP);
    assign rsp_info    = info_q;
    assign rsp_err     = err_q;
    assign mem_rd_en   = (st_q == ST_ARR_RD) || (st_q == ST_NODE_RD);
    assign mem_rd_node = (st_q == ST_NODE_RD);
    assign mem_rd_addr = mem_rd_node ? {1'b0, node_q} : addr_q[ADDR_W-1 -: KEY_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            addr_q  <= '0;
            node_q  <= '0;
            col_q   <= '0;
            depth_q <= '0;
            line_q  <= '0;
            info_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: if (req_valid) begin
                    addr_q  <= req_addr;
                    col_q   <= '0;
                    depth_q <= '0;
                    err_q   <= 1'b0;
                    st_q    <= ST_ARR_RD;
                end
                ST_ARR_RD: st_q <= ST_ARR_WAIT;
                ST_ARR_WAIT: if (mem_rd_valid) begin
                    if (arr_ptr.is_info) begin
                        info_q <= arr_ptr.pay;
                        st_q   <= ST_RESP;
                    end else begin
                        node_q <= arr_ptr.pay;
                        st_q   <= ST_NODE_RD;
                    end
                end
                ST_NODE_RD: begin
                    depth_q <= depth_q + 1'b1;
                    st_q    <= ST_NODE_WAIT;
                end
                ST_NODE_WAIT: if (mem_rd_valid) begin
                    line_q <= mem_rd_data;
                    st_q   <= ST_EVAL;
                end
                ST_EVAL: begin
                    if (pick.is_info) begin
                        info_q <= pick.pay;
                        st_q   <= ST_RESP;
                    end else if (depth_q == DEP_W'(MAX_DEPTH)) begin
                        info_q <= '0;
                        err_q  <= 1'b1;
                        st_q   <= ST_RESP;
                    end else begin
                        node_q <= pick.pay;
                        if (eq_hit && mcol_en && (col_q != LAST_COL))
                            col_q <= col_q + 1'b1;
                        st_q <= ST_NODE_RD;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    a_r9_idle_no_read: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_rd_en);
    a_r9_rsp_single: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
    a_r1_array_first: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && !mem_rd_node) |-> (depth_q == '0));
    a_r8_depth_cap: assert property (@(posedge clk) disable iff (rst)
        depth_q <= DEP_W'(MAX_DEPTH));
    a_r8_err_payload: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (rsp_info == '0));
    a_r7_col_forward: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_IDLE) |=> (col_q >= $past(col_q)));
endmodule

// File: tb/lpm_walker_tb.sv
module lpm_walker_tb;
    localparam int CLK_P     = 10;
    localparam int ADDR_W    = 48;
    localparam int MAX_DEPTH = 4;
    localparam int RD_LAT    = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              mcol_en = 1'b0;
    logic              rsp_valid;
    logic [14:0]       rsp_info;
    logic              rsp_err;
    logic              mem_rd_en;
    logic              mem_rd_node;
    logic [15:0]       mem_rd_addr;
    logic              mem_rd_valid;
    logic [255:0]      mem_rd_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int node_reads = 0;

    always #(CLK_P/2) clk = ~clk;

    lpm_walker #(.ADDR_W(ADDR_W), .MAX_DEPTH(MAX_DEPTH)) u_dut (
        .clk, .rst, .req_valid, .req_ready, .req_addr, .mcol_en,
        .rsp_valid, .rsp_info, .rsp_err,
        .mem_rd_en, .mem_rd_node, .mem_rd_addr, .mem_rd_valid, .mem_rd_data
    );

    // R2: array entry placement and pointer coding
    function automatic logic [15:0] arr_entry(input logic [15:0] idx);
        case (idx)
            16'd0:   return 16'h0000;
            16'd1:   return 16'h0003;
            16'd2:   return 16'h0004;
            default: return {1'b1, idx[14:0]};
        endcase
    endfunction

    // R3: slot layout of a node line
    function automatic logic [255:0] node_line(input int n);
        logic [255:0] l;
        l = '0;
        for (int s = 0; s < 5; s++) l[16*s +: 16] = 16'(s + 1);
        case (n)
            0: begin
                for (int s = 0; s < 5; s++) begin
                    l[16*s +: 16]     = 16'(100 * (s + 1));
                    l[16*(5+s) +: 16] = 16'h8100 + 16'(s);
                end
                for (int j = 0; j < 6; j++) l[16*(10+j) +: 16] = 16'h8200 + 16'(j);
                l[16*7 +: 16]  = 16'h0002;
                l[16*12 +: 16] = 16'h0001;
            end
            1: begin
                l[15:0] = 16'd210; l[31:16] = 16'd220; l[47:32] = 16'd230;
                l[63:48] = 16'hFFFF; l[79:64] = 16'hFFFF;
                for (int s = 0; s < 5; s++) l[16*(5+s) +: 16] = 16'h8300 + 16'(s);
                for (int j = 0; j < 6; j++) l[16*(10+j) +: 16] = 16'h8400 + 16'(j);
            end
            2: begin
                l[15:0] = 16'd10; l[31:16] = 16'd20; l[47:32] = 16'd20;
                l[63:48] = 16'd30; l[79:64] = 16'd40;
                for (int s = 0; s < 5; s++) l[16*(5+s) +: 16] = 16'h8500 + 16'(s);
                for (int j = 0; j < 6; j++) l[16*(10+j) +: 16] = 16'h8600 + 16'(j);
            end
            3, 4, 5, 6: for (int s = 5; s < 16; s++)
                l[16*s +: 16] = (n == 3) ? 16'h0003 : 16'(n + 1);
            7: for (int s = 5; s < 16; s++) l[16*s +: 16] = 16'h8700 + 16'(s);
            default: ;
        endcase
        return l;
    endfunction

    // Memory model with fixed read latency
    logic        pv [RD_LAT];
    logic        ps [RD_LAT];
    logic [15:0] pa [RD_LAT];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RD_LAT; i++) begin pv[i] <= 1'b0; ps[i] <= 1'b0; pa[i] <= '0; end
        end else begin
            pv[0] <= mem_rd_en; ps[0] <= mem_rd_node; pa[0] <= mem_rd_addr;
            for (int i = 1; i < RD_LAT; i++) begin pv[i] <= pv[i-1]; ps[i] <= ps[i-1]; pa[i] <= pa[i-1]; end
            if (mem_rd_en && mem_rd_node) node_reads <= node_reads + 1;
        end
    end

    always_comb begin
        mem_rd_valid = pv[RD_LAT-1];
        if (!pv[RD_LAT-1]) mem_rd_data = '0;
        else if (ps[RD_LAT-1]) mem_rd_data = node_line(int'(pa[RD_LAT-1]));
        else mem_rd_data = {240'b0, arr_entry(pa[RD_LAT-1])};
    end

    // Expected result from R1..R8
    task automatic ref_lookup(input logic [ADDR_W-1:0] a, input bit mc,
                              output logic [14:0] info, output bit err, output int nr);
        logic [15:0] e, p, key;
        logic [255:0] l;
        int node, col, lt, eqi;
        bit done;
        e = arr_entry(a[47:32]);
        info = '0; err = 0; nr = 0; done = 0;
        if (e[15]) begin info = e[14:0]; done = 1; end
        node = int'(e[14:0]); col = 0;
        for (int d = 1; d <= MAX_DEPTH + 1 && !done; d++) begin
            l = node_line(node);
            key = (col == 0) ? a[31:16] : a[15:0];
            lt = 0; eqi = -1;
            for (int i = 4; i >= 0; i--) begin
                if (l[16*i +: 16] == key) eqi = i;
                if (l[16*i +: 16] < key) lt++;
            end
            p = (eqi >= 0) ? l[16*(5+eqi) +: 16] : l[16*(10+lt) +: 16];
            nr = d;
            if (p[15]) begin info = p[14:0]; done = 1; end
            else if (d == MAX_DEPTH) begin err = 1; done = 1; end
            else begin
                node = int'(p[14:0]);
                if (eqi >= 0 && mc && col < 1) col++;
            end
        end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(input logic [ADDR_W-1:0] a, input bit mc, input string req);
        logic [14:0] ei;
        bit ee;
        int en, wait_c;
        ref_lookup(a, mc, ei, ee, en);
        @(negedge clk);
        node_reads = 0;
        req_addr = a; mcol_en = mc; req_valid = 1'b1;
        check(req_ready == 1'b1, "R9 ready when idle", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        wait_c = 0;
        while (!rsp_valid && wait_c < 200) begin @(negedge clk); wait_c++; end
        check(rsp_valid == 1'b1, "R9 response arrives", int'(rsp_valid), 1);
        check(rsp_info == ei, req, int'(rsp_info), int'(ei));
        check(rsp_err == ee, "R8 error flag", int'(rsp_err), int'(ee));
        check(node_reads == en, "R8 node read count", node_reads, en);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R9 single pulse", int'(rsp_valid), 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R10 ready in reset", int'(req_ready), 1);
        check(rsp_valid == 1'b0, "R10 no response in reset", int'(rsp_valid), 0);
        check(mem_rd_en == 1'b0, "R10 no read in reset", int'(mem_rd_en), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(mem_rd_en == 1'b0, "R9 idle no read", int'(mem_rd_en), 0);

        // R1 R2: direct array results, no node reads
        for (int i = 3; i < 40; i++) run({16'(i), 16'h1234, 16'h0}, 0, "R1 direct result");
        run({16'hFFFF, 32'h0}, 0, "R1 top index");
        run({16'h8005, 32'h0}, 1, "R2 flag bit");

        // R3 R4 R5 R6 R7: sweep column 0 through node 0 and subtrees
        for (int v = 0; v <= 620; v++) begin
            run({16'h0000, 16'(v), 16'd20}, 0, "R5 R6 range and equal selection");
            run({16'h0000, 16'(v), 16'd20}, 1, "R4 R7 multicolumn selection");
        end
        // R4: duplicate keys, lowest index wins (second column values)
        for (int w = 0; w <= 50; w++) run({16'h0000, 16'd300, 16'(w)}, 1, "R4 lowest equal index");
        // R5: padded slots
        run({16'h0000, 16'd250, 16'h0}, 0, "R5 above real keys");
        // R8: chain of exact max depth, and a self loop
        run({16'h0002, 32'h0}, 0, "R8 chain at limit");
        run({16'h0001, 32'h0}, 0, "R8 loop aborts");
        run({16'h0001, 32'h0}, 1, "R8 loop aborts mcol");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule